// File: doc/BRIEF.md
# Wiper Position Register Bank

This block holds the tap position of each potentiometer in a multi-channel digitally controlled resistor. Each channel keeps a volatile position code. By default the code is 6 bits wide, giving 64 taps. The block also keeps a registered one-hot vector that turns on exactly one tap switch of that channel's resistor string. Code zero selects the switch at the low terminal. The all-ones code selects the switch at the high terminal.

The surrounding command logic can change a channel's position in four ways:
- A host write places a value from the serial port directly into one channel.
- A transfer copies a value offered by the channel's data-register store. It loads either one channel or every channel at once.
- A step request moves one channel up or down by a single tap. Steps stop at the ends of the range.
- Reset recalls each channel's stored power-up value (register zero of its data-register store).

When requests coincide, the priority is fixed: reset first, then host write, then transfer, then step.

Top module: `wiper_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every channel's position loads from its slice of `recall_bus`, and its tap vector shows that same position. Channel k uses bits [k*WIDTH +: WIDTH]. Reset overrides any request presented in the same cycle.
- R2: When `wr_en` is high, the channel numbered by `wr_pot` takes `wr_data` at the next rising edge. All other channels are unaffected by the write.
- R3: When `xfer_en` is high and `xfer_all` is low, only the channel numbered by `xfer_pot` takes its own slice of `xfer_bus` at the next edge.
- R4: When `xfer_en` and `xfer_all` are both high, every channel takes its own slice of `xfer_bus` at the same edge.
- R5: When `step_en` is high and no load targets the channel `step_pot`, that channel moves by one tap at the next edge. It moves up (toward the high terminal) when `step_up` is 1 and down when it is 0.
- R6: A step saturates. A step up at the all-ones code leaves the code unchanged, and a step down at code zero leaves it unchanged.
- R7: A load beats a step on the same channel in the same cycle. A host write beats a transfer on the same channel in the same cycle.
- R8: Each channel's tap vector has exactly one bit set at all times after reset, and that bit's index equals the channel's position. Bit 0 is the low terminal and bit 2^WIDTH-1 is the high terminal.
- R9: A channel with no request aimed at it keeps both its position and its tap vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; triggers the recall |
| recall_bus | input | NUM_POTS*WIDTH | Power-up value for each channel |
| wr_en | input | 1 | Host direct write request |
| wr_pot | input | SEL_W | Channel addressed by the host write |
| wr_data | input | WIDTH | Value written by the host |
| xfer_en | input | 1 | Transfer request from the data-register store |
| xfer_all | input | 1 | Transfer loads every channel |
| xfer_pot | input | SEL_W | Channel addressed by a single transfer |
| xfer_bus | input | NUM_POTS*WIDTH | Transfer value for each channel |
| step_en | input | 1 | Single-tap step request |
| step_pot | input | SEL_W | Channel addressed by the step |
| step_up | input | 1 | 1 steps toward the high terminal, 0 toward the low terminal |
| pos_bus | output | NUM_POTS*WIDTH | Current position of each channel |
| tap_bus | output | NUM_POTS*2^WIDTH | Registered one-hot tap enable of each channel |

## Verification
The bench targets the following corner cases, each of which a faulty design would get wrong in a visible way:
- **Stepping at the range ends.** A design that wraps would jump the wiper from one terminal straight to the other.
- **Same-cycle collisions.** The bench presents write-plus-step, write-plus-transfer and global-transfer-plus-step together. Wrong priority would leave the stepped or transferred value in place of the written one.
- **Global transfer.** It must reach every channel, not just the addressed one.
- **Reset with a pending write.** Reset must still recall the stored value, not take the write.
- **Tap vector alignment.** The tap vector is compared against the position every cycle. A decoder that lags, is all-zero or is reversed would select the wrong switch or none at all.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   // Which load source a channel takes this cycle (steps are handled apart)
   typedef enum logic [1:0] {
      LD_NONE = 2'd0,
      LD_HOST = 2'd1,
      LD_XFER = 2'd2
   } load_src_e;
endpackage

// File: rtl/wiper_tap_decoder.sv
module wiper_tap_decoder #(
   parameter int WIDTH = 6,
   localparam int TAPS = 1 << WIDTH
) (
   input  logic [WIDTH-1:0] code,
   output logic [TAPS-1:0]  onehot
);
   if (WIDTH < 1 || WIDTH > 10) begin : g_bad_width
      $error("wiper_tap_decoder: WIDTH out of range");
   end

   always_comb begin
      onehot       = '0;
      onehot[code] = 1'b1;
   end
endmodule

// File: rtl/wiper_cell.sv
module wiper_cell
   import wiper_pkg::*;
#(
   parameter int WIDTH    = 6,
   parameter bit SATURATE = 1'b1,
   localparam int TAPS    = 1 << WIDTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] recall_val,
   input  load_src_e        src,
   input  logic [WIDTH-1:0] host_val,
   input  logic [WIDTH-1:0] xfer_val,
   input  logic             step_en,
   input  logic             step_up,
   output logic [WIDTH-1:0] pos,
   output logic [TAPS-1:0]  tap
);
   localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
   localparam logic [WIDTH-1:0] BOT = '0;

   logic [WIDTH-1:0] up_val, dn_val, run_val, nxt_val;
   logic [TAPS-1:0]  nxt_tap;

   if (SATURATE) begin : g_sat
      assign up_val = (pos == TOP) ? pos : pos + 1'b1;
      assign dn_val = (pos == BOT) ? pos : pos - 1'b1;
   end else begin : g_wrap
      assign up_val = pos + 1'b1;
      assign dn_val = pos - 1'b1;
   end

   always_comb begin
      unique case (src)
         LD_HOST: run_val = host_val;
         LD_XFER: run_val = xfer_val;
         default: run_val = step_en ? (step_up ? up_val : dn_val) : pos;
      endcase
      nxt_val = rst_n ? run_val : recall_val;
   end

   wiper_tap_decoder #(.WIDTH(WIDTH)) u_dec (
      .code   (nxt_val),
      .onehot (nxt_tap)
   );

   always_ff @(posedge clk) begin
      pos <= nxt_val;
      tap <= nxt_tap;
   end

   AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot(tap)) else $error("tap not one-hot");                      // R8
   AST_TAP_AT_POS: assert property (@(posedge clk) disable iff (!rst_n)
      tap[pos]) else $error("tap misaligned with position");             // R8
   AST_HOST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == LD_HOST) |=> pos == $past(host_val)) else $error("host load"); // R2
   AST_XFER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == LD_XFER) |=> pos == $past(xfer_val)) else $error("xfer load"); // R3
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (src == LD_NONE && !step_en) |=> ($stable(pos) && $stable(tap)))
      else $error("idle channel moved");                                 // R9
   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (src == LD_NONE && step_en && step_up && pos != TOP)
      |=> pos == $past(pos) + 1'b1) else $error("step up");              // R5
   AST_STEP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (src == LD_NONE && step_en && !step_up && pos != BOT)
      |=> pos == $past(pos) - 1'b1) else $error("step down");            // R5
   if (SATURATE) begin : g_sat_chk
      AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
         (src == LD_NONE && step_en && step_up && pos == TOP)
         |=> pos == TOP) else $error("high saturation");                 // R6
      AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
         (src == LD_NONE && step_en && !step_up && pos == BOT)
         |=> pos == BOT) else $error("low saturation");                  // R6
   end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
   import wiper_pkg::*;
#(
   parameter int NUM_POTS = 4,
   parameter int WIDTH    = 6,
   parameter bit SATURATE = 1'b1,
   localparam int TAPS    = 1 << WIDTH,
   localparam int SEL_W   = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_POTS*WIDTH-1:0] recall_bus,
   input  logic                      wr_en,
   input  logic [SEL_W-1:0]          wr_pot,
   input  logic [WIDTH-1:0]          wr_data,
   input  logic                      xfer_en,
   input  logic                      xfer_all,
   input  logic [SEL_W-1:0]          xfer_pot,
   input  logic [NUM_POTS*WIDTH-1:0] xfer_bus,
   input  logic                      step_en,
   input  logic [SEL_W-1:0]          step_pot,
   input  logic                      step_up,
   output logic [NUM_POTS*WIDTH-1:0] pos_bus,
   output logic [NUM_POTS*TAPS-1:0]  tap_bus
);
   if (NUM_POTS < 1 || NUM_POTS > 64) begin : g_bad_pots
      $error("wiper_bank: NUM_POTS out of range");
   end

   for (genvar i = 0; i < NUM_POTS; i++) begin : g_pot
      logic      host_hit, xfer_hit, step_hit;
      load_src_e src;

      assign host_hit = wr_en && (wr_pot == SEL_W'(i));
      assign xfer_hit = xfer_en && (xfer_all || (xfer_pot == SEL_W'(i)));
      assign step_hit = step_en && (step_pot == SEL_W'(i));
      assign src      = host_hit ? LD_HOST : (xfer_hit ? LD_XFER : LD_NONE);

      wiper_cell #(.WIDTH(WIDTH), .SATURATE(SATURATE)) u_cell (
         .clk        (clk),
         .rst_n      (rst_n),
         .recall_val (recall_bus[i*WIDTH +: WIDTH]),
         .src        (src),
         .host_val   (wr_data),
         .xfer_val   (xfer_bus[i*WIDTH +: WIDTH]),
         .step_en    (step_hit),
         .step_up    (step_up),
         .pos        (pos_bus[i*WIDTH +: WIDTH]),
         .tap        (tap_bus[i*TAPS +: TAPS])
      );
   end

   AST_GLOBAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_en && xfer_all && !wr_en) |=> pos_bus == $past(xfer_bus))
      else $error("global transfer missed a channel");                   // R4
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> pos_bus[WIDTH*$past(wr_pot) +: WIDTH] == $past(wr_data))
      else $error("write lost priority");                                // R7
endmodule

// File: tb/tb_wiper_bank.sv
module tb_wiper_bank;
   localparam int NP = 4;
   localparam int W  = 6;
   localparam int T  = 1 << W;

   logic            clk = 1'b0;
   logic            rst_n;
   logic [NP*W-1:0] recall_bus, xfer_bus;
   logic            wr_en, xfer_en, xfer_all, step_en, step_up;
   logic [1:0]      wr_pot, xfer_pot, step_pot;
   logic [W-1:0]    wr_data;
   logic [NP*W-1:0] pos_bus;
   logic [NP*T-1:0] tap_bus;

   int checks = 0, failures = 0;
   logic [W-1:0] model [NP];

   always #2.5 clk = ~clk;

   wiper_bank #(.NUM_POTS(NP), .WIDTH(W)) dut (.*);

   // op codes: 0 idle, 1 write, 2 single xfer, 3 global xfer, 4 step,
   // 5 write+step same pot, 6 write+xfer same pot, 7 global xfer + step
   // fields: {op[3:0], pot[3:0], data[7:0], up[3:0], exp_of_pot[7:0]}
   localparam logic [27:0] VEC [15] = '{
      28'h1_1_07_0_07, 28'h4_1_00_1_08, 28'h4_1_00_0_07, 28'h4_3_00_1_3F,
      28'h4_2_00_0_00, 28'h2_2_10_0_12, 28'h3_0_20_0_20, 28'h5_0_05_1_05,
      28'h6_3_31_0_31, 28'h0_3_00_0_31, 28'h1_0_3F_0_3F, 28'h4_0_00_1_3F,
      28'h1_0_00_0_00, 28'h4_0_00_0_00, 28'h7_1_0A_1_0B
   };

   function automatic string req_of(int op);
      case (op)
         0: return "R9";  1: return "R2";  2: return "R3";  3: return "R4";
         4: return "R5/R6"; 5: return "R7"; 6: return "R7"; default: return "R7/R4";
      endcase
   endfunction

   task automatic check_all(string tag);
      for (int k = 0; k < NP; k++) begin
         logic [T-1:0] exp_tap;
         exp_tap = '0;
         exp_tap[model[k]] = 1'b1;
         checks++;
         if (pos_bus[k*W +: W] !== model[k] || tap_bus[k*T +: T] !== exp_tap) begin
            failures++;
            $display("FAIL %s pot%0d pos=%h tap=%h expected pos=%h tap=%h (R8 alignment)",
                     tag, k, pos_bus[k*W +: W], tap_bus[k*T +: T], model[k], exp_tap);
         end
      end
   endtask

   task automatic clear_in();
      wr_en = 0; xfer_en = 0; xfer_all = 0; step_en = 0; step_up = 0;
      wr_pot = 0; xfer_pot = 0; step_pot = 0; wr_data = 0; xfer_bus = '0;
   endtask

   task automatic run_op(int op, int pot, logic [W-1:0] data, bit up, logic [W-1:0] exp);
      @(negedge clk);
      clear_in();
      for (int k = 0; k < NP; k++) xfer_bus[k*W +: W] = data ^ W'(k);
      case (op)
         1: begin wr_en = 1; wr_pot = 2'(pot); wr_data = data; model[pot] = data; end
         2: begin xfer_en = 1; xfer_pot = 2'(pot); model[pot] = data ^ W'(pot); end
         3: begin xfer_en = 1; xfer_all = 1;
                  for (int k = 0; k < NP; k++) model[k] = data ^ W'(k); end
         4: begin step_en = 1; step_pot = 2'(pot); step_up = up;
                  if (up && model[pot] != 6'h3F) model[pot] = model[pot] + 1'b1;
                  else if (!up && model[pot] != 6'h00) model[pot] = model[pot] - 1'b1; end
         5: begin wr_en = 1; wr_pot = 2'(pot); wr_data = data;
                  step_en = 1; step_pot = 2'(pot); step_up = up; model[pot] = data; end
         6: begin wr_en = 1; wr_pot = 2'(pot); wr_data = data;
                  xfer_en = 1; xfer_pot = 2'(pot); model[pot] = data; end
         7: begin xfer_en = 1; xfer_all = 1; step_en = 1; step_pot = 2'(pot); step_up = up;
                  for (int k = 0; k < NP; k++) model[k] = data ^ W'(k); end
         default: ;
      endcase
      @(posedge clk); #1;
      checks++;
      if (pos_bus[pot*W +: W] !== exp) begin
         failures++;
         $display("FAIL %s op%0d pot%0d pos=%h expected %h", req_of(op), op, pot,
                  pos_bus[pot*W +: W], exp);
      end
      check_all(req_of(op));
   endtask

   initial begin
      #(200000 * 5);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      clear_in();
      rst_n = 0;
      recall_bus = {6'h3F, 6'h00, 6'h15, 6'h2A};
      for (int k = 0; k < NP; k++) model[k] = recall_bus[k*W +: W];
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      check_all("R1 reset recall");

      for (int v = 0; v < 15; v++)
         run_op(int'(VEC[v][27:24]), int'(VEC[v][23:20]), VEC[v][17:12],
                VEC[v][8], VEC[v][5:0]);

      // R1: reset again with new recall values and a write pending
      @(negedge clk);
      clear_in();
      rst_n = 0; recall_bus = {6'h01, 6'h3E, 6'h20, 6'h11};
      wr_en = 1; wr_pot = 2'd2; wr_data = 6'h05;
      for (int k = 0; k < NP; k++) model[k] = recall_bus[k*W +: W];
      @(posedge clk); #1;
      check_all("R1 reset beats write");
      @(negedge clk); clear_in(); rst_n = 1;
      @(posedge clk); #1;
      check_all("R9 hold after reset");

      // R6: step down from the low end repeatedly stays at 00
      run_op(1, 3, 6'h00, 0, 6'h00);
      run_op(4, 3, 6'h00, 0, 6'h00);
      run_op(4, 3, 6'h00, 1, 6'h01);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule